// File: doc/BRIEF.md
# Selectable-Source Integer Clock Divider

This block takes one of several source clocks and divides it by a whole number from 1 to 64. All of its settings sit in one control word: a 6-bit divide field, a stop bit and a source-select field. Software writes that word through a simple write port and can read it back at any time.

The block runs on a single system clock. Each source clock reaches it as a one-cycle tick strobe, already brought into the system domain, with one tick per source edge. The divided clock leaves the block in two forms. `clk_pulse` marks the start of each output period. `clk_level` is the divided waveform, high for the first half of the period.

Two dedicated strobes act on the control word as one operation each. A disable strobe parks the divider in a state from which the stop always holds. An enable strobe reloads a ratio and then restarts the output. Three rules keep the output free of glitches:
- A ratio change waits for the end of the current output period.
- A source change holds the output low while the new source settles.
- A stop written together with a zero divide field is refused.

Top module: `clkdiv`

## Requirements
- R1: With divide field value k, the block emits one `clk_pulse` every k+1 ticks of the selected source. Each pulse lasts one system clock cycle.
- R2: While the stop bit (control bit 8) is set, `clk_pulse` and `clk_level` stay low. Clearing the bit restarts the count from the first phase of a period.
- R3: A register write that sets the stop bit while its divide field (bits 5:0) is zero leaves the stop bit at its previous value. The divide and source fields of that write still take effect.
- R4: A disable strobe sets the stop bit and forces the divide field to 63 (all ones), with the new value readable the next cycle.
- R5: The source-select field sits at bits 13:12. A write that carries a value of 3 or more (at least the number of sources) leaves the field unchanged. A valid value routes ticks from the source with that index.
- R6: An enable strobe loads the divide field from `en_div` on the first edge and clears the stop bit on the following edge.
- R7: A new divide value is applied to the output only when the current output period ends. An output period already in progress is never shortened or stretched.
- R8: For ratio r, `clk_level` is high for floor(r/2) source ticks and low for the rest of the period. At ratio 1, every source tick gives a pulse and the level stays low.
- R9: After the source field changes, the outputs stay low for 3 system cycles and the divide count restarts from zero.
- R10: Reading returns the divide field in bits 5:0, the stop bit in bit 8 and the source field in bits 13:12. All other bits read zero. The reset value is all zero.
- R11: When strobes arrive together, disable takes priority over enable, and enable takes priority over a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| dis_req | input | 1 | Disable operation strobe |
| en_req | input | 1 | Enable operation strobe |
| en_div | input | 6 | Divide field to load on enable |
| src_tick | input | 3 | One tick strobe per source clock |
| rd_data | output | 16 | Current control word |
| clk_pulse | output | 1 | Start-of-period strobe of the divided clock |
| clk_level | output | 1 | Divided clock waveform |

## Verification
The three sources tick in three different patterns: every cycle, every second cycle, and an irregular pseudo-random stream. A routing fault therefore changes the pulse spacing and does not hide. Ratio changes arrive in the middle of a period, which separates a boundary-timed update from an immediate one. Odd and even ratios, together with ratio 1, separate the high-phase rule from the pass-through case. Stop writes with zero and non-zero divide fields, invalid source values, and colliding strobes exercise the register rules. A behavioural model checks every cycle against the design.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W = 6;
  typedef logic [DIV_W-1:0] div_t;
  typedef logic [DIV_W:0]   ratio_t;

  // field value k divides by k+1
  function automatic ratio_t ratio_of(input div_t f);
    return {1'b0, f} + ratio_t'(1);
  endfunction

  // number of ticks the level stays high in one period
  function automatic ratio_t high_len(input div_t f);
    return ratio_of(f) >> 1;
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int STOP_BIT  = 8,
  parameter int SRC_SHIFT = 12,
  parameter int SRC_W     = 2,
  parameter int NUM_SRC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             dis_req,
  input  logic             en_req,
  input  div_t             en_div,
  output div_t             div_q,
  output logic             stop_q,
  output logic [SRC_W-1:0] src_q,
  output logic             en_pend,
  output logic             stop_reject,
  output logic [REG_W-1:0] rd_data
);
  div_t             wr_div;
  logic             wr_stop;
  logic [SRC_W-1:0] wr_src;
  logic             src_ok;

  assign wr_div      = wr_data[DIV_W-1:0];
  assign wr_stop     = wr_data[STOP_BIT];
  assign wr_src      = wr_data[SRC_SHIFT +: SRC_W];
  assign src_ok      = ({1'b0, wr_src} < (SRC_W+1)'(NUM_SRC));
  assign stop_reject = wr_stop && (wr_div == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      stop_q  <= 1'b0;
      src_q   <= '0;
      en_pend <= 1'b0;
    end else if (dis_req) begin
      stop_q  <= 1'b1;
      div_q   <= '1;
      en_pend <= 1'b0;
    end else if (en_req) begin
      div_q   <= en_div;
      en_pend <= 1'b1;
    end else begin
      if (en_pend) begin
        stop_q  <= 1'b0;
        en_pend <= 1'b0;
      end
      if (wr_en) begin
        div_q <= wr_div;
        if (src_ok)       src_q  <= wr_src;
        if (!stop_reject) stop_q <= wr_stop;
      end
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[DIV_W-1:0]            = div_q;
    rd_data[STOP_BIT]             = stop_q;
    rd_data[SRC_SHIFT +: SRC_W]   = src_q;
  end
endmodule

// File: rtl/clkdiv_srcsel.sv
module clkdiv_srcsel #(
  parameter int NUM_SRC  = 3,
  parameter int SRC_W    = 2,
  parameter int SYNC_LEN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_W-1:0]   src_q,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               sel_tick,
  output logic               settling
);
  localparam int HOLD_W = $clog2(SYNC_LEN + 1);

  logic [SRC_W-1:0]  src_act;
  logic [HOLD_W-1:0] hold;
  logic              swap;

  assign swap     = (src_q != src_act);
  assign settling = swap || (hold != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_act <= '0;
      hold    <= '0;
    end else if (swap) begin
      src_act <= src_q;
      hold    <= HOLD_W'(SYNC_LEN);
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end
  end

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_act == SRC_W'(i)) sel_tick = src_tick[i];
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic freeze,
  input  div_t div_q,
  output div_t act_div,
  output logic wrap,
  output logic clk_pulse,
  output logic clk_level
);
  div_t cnt, nxt_cnt, nxt_act;
  logic last_phase;

  assign last_phase = (cnt >= act_div);
  assign wrap       = tick && !freeze && last_phase;

  always_comb begin
    nxt_cnt = cnt;
    nxt_act = act_div;
    if (freeze) begin
      nxt_cnt = '0;
      nxt_act = div_q;
    end else if (tick) begin
      if (last_phase) begin
        nxt_cnt = '0;
        nxt_act = div_q;
      end else begin
        nxt_cnt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_div   <= '0;
      clk_pulse <= 1'b0;
      clk_level <= 1'b0;
    end else begin
      cnt       <= nxt_cnt;
      act_div   <= nxt_act;
      clk_pulse <= wrap;
      clk_level <= !freeze && (high_len(nxt_act) > {1'b0, nxt_cnt});
    end
  end
endmodule

// File: rtl/clkdiv.sv
module clkdiv
  import clkdiv_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int STOP_BIT  = 8,
  parameter int SRC_SHIFT = 12,
  parameter int SRC_W     = 2,
  parameter int NUM_SRC   = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               dis_req,
  input  logic               en_req,
  input  logic [DIV_W-1:0]   en_div,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [REG_W-1:0]   rd_data,
  output logic               clk_pulse,
  output logic               clk_level
);
  div_t             div_q, act_div;
  logic             stop_q, en_pend, stop_reject;
  logic [SRC_W-1:0] src_q;
  logic             sel_tick, settling, freeze, wrap;

  assign freeze = stop_q || settling;

  clkdiv_ctrl #(
    .REG_W(REG_W), .STOP_BIT(STOP_BIT), .SRC_SHIFT(SRC_SHIFT),
    .SRC_W(SRC_W), .NUM_SRC(NUM_SRC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dis_req(dis_req), .en_req(en_req), .en_div(en_div),
    .div_q(div_q), .stop_q(stop_q), .src_q(src_q), .en_pend(en_pend),
    .stop_reject(stop_reject), .rd_data(rd_data)
  );

  clkdiv_srcsel #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .SYNC_LEN(SYNC_LEN)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .src_q(src_q), .src_tick(src_tick),
    .sel_tick(sel_tick), .settling(settling)
  );

  clkdiv_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(sel_tick), .freeze(freeze),
    .div_q(div_q), .act_div(act_div), .wrap(wrap),
    .clk_pulse(clk_pulse), .clk_level(clk_level)
  );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
  import clkdiv_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int STOP_BIT = 8,
  parameter int SRC_W    = 2,
  parameter int NUM_SRC  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             dis_req,
  input logic             en_req,
  input div_t             en_div,
  input div_t             div_q,
  input div_t             act_div,
  input logic             stop_q,
  input logic [SRC_W-1:0] src_q,
  input logic             en_pend,
  input logic             freeze,
  input logic             clk_pulse,
  input logic             clk_level
);
  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> (!clk_pulse && !clk_level));

  p_stop_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dis_req && !en_req && !en_pend && wr_data[STOP_BIT] &&
     (wr_data[DIV_W-1:0] == '0)) |=> (stop_q == $past(stop_q)));

  p_disable_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> (stop_q && (div_q == '1)));

  p_src_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(src_q) < NUM_SRC);

  p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !dis_req) |=> (en_pend && (div_q == $past(en_div))));

  p_enable_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pend && !dis_req && !en_req) |=> !stop_q);

  p_ratio_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(freeze) && (act_div != $past(act_div))) |-> clk_pulse);

  p_swap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q != $past(src_q)) |=> (!clk_pulse && !clk_level));
endmodule

bind clkdiv clkdiv_chk #(
  .REG_W(REG_W), .STOP_BIT(STOP_BIT), .SRC_W(SRC_W), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .dis_req(dis_req), .en_req(en_req), .en_div(en_div),
  .div_q(div_q), .act_div(act_div), .stop_q(stop_q), .src_q(src_q),
  .en_pend(en_pend), .freeze(freeze), .clk_pulse(clk_pulse),
  .clk_level(clk_level)
);

// File: tb/clkdiv_bench.sv
`timescale 1ns/1ps
module clkdiv_bench;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        dis_req = 1'b0;
  logic        en_req = 1'b0;
  logic [5:0]  en_div = '0;
  logic [2:0]  src_tick = 3'b001;
  logic [15:0] rd_data;
  logic        clk_pulse, clk_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  clkdiv u_clkdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dis_req(dis_req), .en_req(en_req), .en_div(en_div),
    .src_tick(src_tick), .rd_data(rd_data),
    .clk_pulse(clk_pulse), .clk_level(clk_level)
  );

  // source tick patterns: every cycle, every other cycle, pseudo-random
  int lfsr = 5'h13;
  always @(negedge clk) begin
    lfsr = ((lfsr << 1) | (((lfsr >> 4) ^ (lfsr >> 2)) & 1)) & 31;
    src_tick[0] <= 1'b1;
    src_tick[1] <= ~src_tick[1];
    src_tick[2] <= lfsr[0];
  end

  // behavioural reference
  int m_div, m_stop, m_src, m_pend, m_asrc, m_hold, m_cnt, m_act, m_pulse, m_lvl;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_stop = 0; m_src = 0; m_pend = 0; m_asrc = 0;
      m_hold = 0; m_cnt = 0; m_act = 0; m_pulse = 0; m_lvl = 0;
    end else begin
      int n_div, n_stop, n_src, n_pend, n_asrc, n_hold, n_cnt, n_act;
      int wdiv, wstop, wsrc, frz, tk;
      bit settle;
      settle = (m_src != m_asrc) || (m_hold > 0);
      frz = (m_stop != 0) || settle;
      tk  = src_tick[m_asrc];
      n_div = m_div; n_stop = m_stop; n_src = m_src; n_pend = m_pend;
      wdiv = wr_data & 63; wstop = (wr_data >> 8) & 1; wsrc = (wr_data >> 12) & 3;
      if (dis_req) begin n_stop = 1; n_div = 63; n_pend = 0; end
      else if (en_req) begin n_div = en_div; n_pend = 1; end
      else begin
        if (m_pend != 0) begin n_stop = 0; n_pend = 0; end
        if (wr_en) begin
          n_div = wdiv;
          if (wsrc < 3) n_src = wsrc;
          if (!(wstop == 1 && wdiv == 0)) n_stop = wstop;
        end
      end
      n_asrc = m_asrc; n_hold = m_hold;
      if (m_src != m_asrc) begin n_asrc = m_src; n_hold = SYNC; end
      else if (m_hold > 0) n_hold = m_hold - 1;
      n_cnt = m_cnt; n_act = m_act; m_pulse = 0;
      if (frz != 0) begin n_cnt = 0; n_act = m_div; end
      else if (tk != 0) begin
        if (m_cnt >= m_act) begin n_cnt = 0; n_act = m_div; m_pulse = 1; end
        else n_cnt = m_cnt + 1;
      end
      m_lvl = (frz == 0) && (n_cnt < (n_act + 1) / 2);
      m_div = n_div; m_stop = n_stop; m_src = n_src; m_pend = n_pend;
      m_asrc = n_asrc; m_hold = n_hold; m_cnt = n_cnt; m_act = n_act;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(clk_pulse == m_pulse, "R1 R7 pulse", clk_pulse, m_pulse);
      check(clk_level == m_lvl, "R8 level", clk_level, m_lvl);
      check(rd_data == ((m_stop << 8) | (m_src << 12) | m_div), "R10 readback",
            rd_data, (m_stop << 8) | (m_src << 12) | m_div);
    end
  end

  task automatic write_reg(input int v);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'(v);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int gap, hi;
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'h0000, "R10 reset value", rd_data, 0);

    // R8: ratio 1 passes every tick of source 0
    wait_cycles(3);
    for (int i = 0; i < 4; i++) begin
      check(clk_pulse == 1'b1 && clk_level == 1'b0, "R8 ratio one", clk_pulse, 1);
      @(negedge clk);
    end

    // R1/R8: ratio 5 on source 0 -> gap 5, two high cycles
    write_reg(4);
    wait_cycles(12);
    while (!clk_pulse) @(negedge clk);
    gap = 0; hi = 0;
    do begin
      if (clk_level) hi++;
      gap++;
      @(negedge clk);
    end while (!clk_pulse);
    check(gap == 5, "R1 period", gap, 5);
    check(hi == 2, "R8 high phase", hi, 2);

    // R7: mid-period ratio changes
    write_reg(7); wait_cycles(3); write_reg(2); wait_cycles(20);
    write_reg(5); wait_cycles(25);

    // R3: stop with zero divide field refused
    write_reg(16'h0100);
    check(rd_data[8] == 1'b0, "R3 stop refused", rd_data[8], 0);
    check(rd_data[5:0] == 6'd0, "R3 divide written", rd_data[5:0], 0);
    wait_cycles(5);

    // R2: stop with non-zero field
    write_reg(16'h0103);
    check(rd_data[8] == 1'b1, "R2 stop set", rd_data[8], 1);
    wait_cycles(2);
    for (int i = 0; i < 6; i++) begin
      check(!clk_pulse && !clk_level, "R2 output halted", clk_pulse, 0);
      @(negedge clk);
    end
    write_reg(16'h0003); wait_cycles(15);

    // R5: invalid source refused, valid one taken
    write_reg(16'h3003);
    check(rd_data[13:12] == 2'd0, "R5 invalid source", rd_data[13:12], 0);
    write_reg(16'h1002);
    check(rd_data[13:12] == 2'd1, "R5 source one", rd_data[13:12], 1);
    // R9: three quiet cycles after the swap edge
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!clk_pulse && !clk_level, "R9 settle low", clk_pulse, 0);
    end
    wait_cycles(30);
    write_reg(16'h2001); wait_cycles(40);
    write_reg(16'h2004); wait_cycles(40);

    // R4: disable forces all ones
    @(negedge clk); dis_req = 1'b1;
    @(negedge clk); dis_req = 1'b0;
    check(rd_data == 16'h213F, "R4 disable word", rd_data, 16'h213F);
    wait_cycles(4);

    // R6: enable loads divide, then clears stop
    @(negedge clk); en_req = 1'b1; en_div = 6'd3;
    @(negedge clk); en_req = 1'b0;
    check(rd_data == 16'h2103, "R6 divide first", rd_data, 16'h2103);
    @(negedge clk);
    check(rd_data == 16'h2003, "R6 stop cleared", rd_data, 16'h2003);
    wait_cycles(40);

    // R11: all strobes together, disable wins
    @(negedge clk); dis_req = 1'b1; en_req = 1'b1; en_div = 6'd1;
    wr_en = 1'b1; wr_data = 16'h0002;
    @(negedge clk); dis_req = 1'b0; en_req = 1'b0; wr_en = 1'b0;
    check(rd_data == 16'h213F, "R11 disable priority", rd_data, 16'h213F);
    @(negedge clk); en_req = 1'b1; en_div = 6'd1; wr_en = 1'b1; wr_data = 16'h0005;
    @(negedge clk); en_req = 1'b0; wr_en = 1'b0;
    check(rd_data[5:0] == 6'd1, "R11 enable over write", rd_data[5:0], 1);
    wait_cycles(30);

    finish_run();
  end
endmodule